// File: doc/BRIEF.md
# Condition Code Flag Generator

This block keeps the eight-bit condition code register of a small processor core and refreshes its four arithmetic flags (negative, zero, overflow, carry) after each operation. The execute stage supplies both operands, the result it has already computed, a class code (add, subtract, test/load, shift), a width select for byte or word operations, and the carry a shifter produced. The block derives the flags from sign-bit logic on operands and result. The ALU and the branch condition logic sit outside it.

Carry and overflow for add and subtract come from bitwise majority terms on A, B and R, taken at the sign bit of the selected width. A shift takes its carry from the shifter and sets overflow to negative XOR carry. A test/load clears overflow and leaves carry untouched. The four upper bits (stop-disable, interrupt-mask-2, half-carry, interrupt-mask) change only when the whole register is written. A whole-register write wins over a flag update in the same cycle.

Top module: `ccr_flag_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it, the register reads 0xD0.
- R2: For an add (class 0), C becomes the sign bit of (A&B)|(B&~R)|(A&~R). With R = A+B this is the unsigned carry out of the selected width.
- R3: For an add, V becomes the sign bit of (A&B&~R)|(~A&~B&R). This is two's-complement overflow of A+B.
- R4: For a subtract (class 1), C becomes the sign bit of (~A&B)|(B&R)|(~A&R). With R = A-B this is the borrow, set when A < B unsigned.
- R5: For a subtract, V becomes the sign bit of (A&~B&~R)|(~A&B&R). This is two's-complement overflow of A-B.
- R6: For a test/load (class 2), V is cleared and C keeps its previous value.
- R7: For a shift (class 3), C takes the shift carry input and V becomes N XOR that new C.
- R8: The sign bit is bit 7 when wide=0 and bit 15 when wide=1. N equals the result's sign bit. Z is set exactly when the result's low 8 bits (wide=0) or all 16 bits (wide=1) are zero. Bits above the selected width have no effect.
- R9: A flag update never alters register bits 7..4.
- R10: When wr_en is high, the register takes wr_data in full on the next edge, even if upd_en is also high.
- R11: With upd_en and wr_en both low, the register holds its value.
- R12: Bit order from bit 7 to bit 0 is S, X, H, I, N, Z, V, C. The outputs flag_n, flag_z, flag_v and flag_c equal bits 3, 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Apply a flag update at the next edge |
| op_class | input | 2 | 0 add, 1 subtract, 2 test/load, 3 shift |
| wide | input | 1 | 1 selects 16-bit width, 0 selects 8-bit |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B |
| result | input | 16 | Result R from the datapath |
| shift_carry | input | 1 | Carry produced by a shift |
| wr_en | input | 1 | Whole-register write enable |
| wr_data | input | 8 | Whole-register write value |
| ccr_q | output | 8 | Register contents |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
The flag logic is combinational and feeds a single register, so every update or write is visible on ccr_q and the flag outputs exactly one clock edge after it is presented. The bench drives each stimulus at a falling edge and compares at the next falling edge. That point lies just after the one register stage and before the following stimulus can land. Expected flags come from integer sums and differences in the bench, not from the majority equations. The bench model carries the previous carry so that test/load retention and shift overflow are predicted from its own state.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'd0,
    CLS_SUB   = 2'd1,
    CLS_TEST  = 2'd2,
    CLS_SHIFT = 2'd3
  } op_class_e;

  // Register layout, bit 7 down to bit 0: S X H I N Z V C
  localparam int CCR_W  = 8;
  localparam int BIT_C  = 0;
  localparam int BIT_V  = 1;
  localparam int BIT_Z  = 2;
  localparam int BIT_N  = 3;
  localparam int ARITH_LO = 0;
  localparam int ARITH_HI = 3;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } nzvc_t;

endpackage

// File: rtl/ccr_lane.sv
// Flag evaluation for one operand width.
module ccr_lane
  import ccr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [1:0]   op_class_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] r_i,
  input  logic         shift_c_i,
  input  logic         c_prev_i,
  output nzvc_t        flags_o
);

  localparam int MSB = W - 1;

  function automatic logic add_carry(input logic [W-1:0] a, b, r);
    logic [W-1:0] t;
    t = (a & b) | (b & ~r) | (a & ~r);
    return t[MSB];
  endfunction

  function automatic logic add_ovf(input logic [W-1:0] a, b, r);
    logic [W-1:0] t;
    t = (a & b & ~r) | (~a & ~b & r);
    return t[MSB];
  endfunction

  function automatic logic sub_borrow(input logic [W-1:0] a, b, r);
    logic [W-1:0] t;
    t = (~a & b) | (b & r) | (~a & r);
    return t[MSB];
  endfunction

  function automatic logic sub_ovf(input logic [W-1:0] a, b, r);
    logic [W-1:0] t;
    t = (a & ~b & ~r) | (~a & b & r);
    return t[MSB];
  endfunction

  op_class_e cls;
  logic      res_neg;
  logic      res_zero;

  assign cls      = op_class_e'(op_class_i);
  assign res_neg  = r_i[MSB];
  assign res_zero = (r_i == '0);

  always_comb begin
    flags_o.n = res_neg;
    flags_o.z = res_zero;
    unique case (cls)
      CLS_ADD: begin
        flags_o.c = add_carry(a_i, b_i, r_i);
        flags_o.v = add_ovf(a_i, b_i, r_i);
      end
      CLS_SUB: begin
        flags_o.c = sub_borrow(a_i, b_i, r_i);
        flags_o.v = sub_ovf(a_i, b_i, r_i);
      end
      CLS_TEST: begin
        flags_o.c = c_prev_i;
        flags_o.v = 1'b0;
      end
      default: begin
        flags_o.c = shift_c_i;
        flags_o.v = res_neg ^ shift_c_i;
      end
    endcase
  end

endmodule

// File: rtl/ccr_reg.sv
// Condition code storage; whole-register write outranks a flag update.
module ccr_reg
  import ccr_pkg::*;
#(
  parameter logic [CCR_W-1:0] RST_VAL = 8'hD0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_fire_i,
  input  logic             wr_fire_i,
  input  logic [CCR_W-1:0] wr_data_i,
  input  nzvc_t            flags_i,
  output logic [CCR_W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= RST_VAL;
    end else if (wr_fire_i) begin
      q_o <= wr_data_i;
    end else if (upd_fire_i) begin
      q_o[ARITH_HI:ARITH_LO] <= flags_i;
    end
  end

endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
  import ccr_pkg::*;
#(
  parameter int                DATA_W   = 16,
  parameter int                NARROW_W = 8,
  parameter logic [CCR_W-1:0]  RST_VAL  = 8'hD0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [1:0]        op_class,
  input  logic              wide,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] result,
  input  logic              shift_carry,
  input  logic              wr_en,
  input  logic [CCR_W-1:0]  wr_data,
  output logic [CCR_W-1:0]  ccr_q,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);

  localparam int NUM_LANES = 2;

  nzvc_t lane_flags [NUM_LANES];
  nzvc_t sel_flags;
  logic  upd_fire;
  logic  wr_fire;
  logic  c_prev;

  assign wr_fire  = wr_en;
  assign upd_fire = upd_en & ~wr_en;
  assign c_prev   = ccr_q[BIT_C];

  for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
    localparam int LW = (gi == 0) ? NARROW_W : DATA_W;
    ccr_lane #(.W(LW)) u_lane (
      .op_class_i (op_class),
      .a_i        (opnd_a[LW-1:0]),
      .b_i        (opnd_b[LW-1:0]),
      .r_i        (result[LW-1:0]),
      .shift_c_i  (shift_carry),
      .c_prev_i   (c_prev),
      .flags_o    (lane_flags[gi])
    );
  end

  assign sel_flags = wide ? lane_flags[1] : lane_flags[0];

  ccr_reg #(.RST_VAL(RST_VAL)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_fire_i (upd_fire),
    .wr_fire_i  (wr_fire),
    .wr_data_i  (wr_data),
    .flags_i    (sel_flags),
    .q_o        (ccr_q)
  );

  assign flag_n = ccr_q[BIT_N];
  assign flag_z = ccr_q[BIT_Z];
  assign flag_v = ccr_q[BIT_V];
  assign flag_c = ccr_q[BIT_C];

endmodule

// File: rtl/ccr_flag_chk.sv
module ccr_flag_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        upd_fire,
  input logic        wr_fire,
  input logic [1:0]  op_class,
  input logic        wide,
  input logic [15:0] result,
  input logic        shift_carry,
  input logic [7:0]  wr_data,
  input logic [7:0]  ccr_q
);

  p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> ccr_q == $past(wr_data));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_fire && !upd_fire) |=> $stable(ccr_q));

  p_upper_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> ccr_q[7:4] == $past(ccr_q[7:4]));

  p_test_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && op_class == 2'd2) |=> (!ccr_q[1] && ccr_q[0] == $past(ccr_q[0])));

  p_shift_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && op_class == 2'd3) |=>
      (ccr_q[0] == $past(shift_carry) && ccr_q[1] == (ccr_q[3] ^ ccr_q[0])));

  p_zero_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_fire |=> ccr_q[2] == ($past(wide) ? ($past(result) == 16'h0)
                                          : ($past(result[7:0]) == 8'h0)));

endmodule

bind ccr_flag_unit ccr_flag_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_fire    (upd_fire),
  .wr_fire     (wr_fire),
  .op_class    (op_class),
  .wide        (wide),
  .result      (result),
  .shift_carry (shift_carry),
  .wr_data     (wr_data),
  .ccr_q       (ccr_q)
);

// File: tb/sim_ccr_flag_unit.sv
module sim_ccr_flag_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic [1:0]  op_class = 2'd0;
  logic        wide = 1'b0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic [15:0] result = '0;
  logic        shift_carry = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  ccr_q;
  logic        flag_n, flag_z, flag_v, flag_c;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 0;
  logic [7:0] m_ccr;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccr_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
    .wide(wide), .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
    .shift_carry(shift_carry), .wr_en(wr_en), .wr_data(wr_data),
    .ccr_q(ccr_q), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
    .flag_c(flag_c)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Compare the full register and the flag outputs against the model.
  task automatic chk_all(input string tc, input string tv);
    chk(tc, {7'd0, ccr_q[0]}, {7'd0, m_ccr[0]});
    chk(tv, {7'd0, ccr_q[1]}, {7'd0, m_ccr[1]});
    chk("R8", {6'd0, ccr_q[3:2]}, {6'd0, m_ccr[3:2]});
    chk("R9", {4'd0, ccr_q[7:4]}, {4'd0, m_ccr[7:4]});
    chk("R12", {4'd0, flag_n, flag_z, flag_v, flag_c}, {4'd0, m_ccr[3:0]});
  endtask

  function automatic longint sgn(input longint v, input int w);
    return (v >= (longint'(1) << (w-1))) ? v - (longint'(1) << w) : v;
  endfunction

  task automatic do_op(input logic [1:0] cls, input logic w, input logic [15:0] a,
                       input logic [15:0] b, input logic [15:0] r, input logic sc);
    int     bw;
    longint mask, am, bm, rm, sa, sb, lim;
    logic   en, ez, ev, ec;
    string  tc, tv;
    bw   = w ? 16 : 8;
    mask = (longint'(1) << bw) - 1;
    am = longint'(a) & mask;
    bm = longint'(b) & mask;
    rm = longint'(r) & mask;
    sa = sgn(am, bw);
    sb = sgn(bm, bw);
    lim = longint'(1) << (bw-1);
    en = ((rm >> (bw-1)) & 1) != 0;
    ez = (rm == 0);
    case (cls)
      2'd0: begin
        ec = (am + bm) > mask;
        ev = (sa + sb) >= lim || (sa + sb) < -lim;
        tc = "R2"; tv = "R3";
      end
      2'd1: begin
        ec = am < bm;
        ev = (sa - sb) >= lim || (sa - sb) < -lim;
        tc = "R4"; tv = "R5";
      end
      2'd2: begin
        ec = m_ccr[0];
        ev = 1'b0;
        tc = "R6"; tv = "R6";
      end
      default: begin
        ec = sc;
        ev = en ^ sc;
        tc = "R7"; tv = "R7";
      end
    endcase
    op_class = cls; wide = w; opnd_a = a; opnd_b = b; result = r;
    shift_carry = sc; upd_en = 1'b1; wr_en = 1'b0;
    m_ccr[3:0] = {en, ez, ev, ec};
    @(negedge clk);
    chk_all(tc, tv);
  endtask

  function automatic logic [15:0] v16(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'h8001;
      default: return 16'(i * 16'h1357 + 16'h0F0F);
    endcase
  endfunction

  initial begin
    m_ccr = 8'hD0;
    #(CLK_PERIOD * 3 + 2);
    chk("R1", ccr_q, 8'hD0);          // during reset
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", ccr_q, 8'hD0);          // first cycle after reset

    // R2 R3 R8: byte adds, upper bytes carry junk that must not matter
    for (int ai = 0; ai < 256; ai += 15)
      for (int bi = 0; bi < 256; bi++) begin
        logic [15:0] a, b;
        a = {8'h5A, 8'(ai)};
        b = {8'hC3, 8'(bi)};
        do_op(2'd0, 1'b0, a, b, a + b, 1'b0);
      end
    // R4 R5: byte subtracts
    for (int ai = 0; ai < 256; ai += 15)
      for (int bi = 0; bi < 256; bi++) begin
        logic [15:0] a, b;
        a = {8'hA7, 8'(ai)};
        b = {8'h3C, 8'(bi)};
        do_op(2'd1, 1'b0, a, b, a - b, 1'b0);
      end
    // Word adds and subtracts over a spread of values
    for (int i = 0; i < 24; i++)
      for (int j = 0; j < 24; j++) begin
        do_op(2'd0, 1'b1, v16(i), v16(j), v16(i) + v16(j), 1'b0);
        do_op(2'd1, 1'b1, v16(i), v16(j), v16(i) - v16(j), 1'b0);
      end

    // R7 then R6: shifts set C, a following test keeps it
    for (int ri = 0; ri < 256; ri++)
      for (int sc = 0; sc < 2; sc++) begin
        do_op(2'd3, 1'b0, 16'h0, 16'h0, {8'hFF, 8'(ri)}, sc[0]);
        do_op(2'd2, 1'b0, 16'h0, 16'h0, {8'h11, 8'(ri ^ 8'h80)}, ~sc[0]);
      end
    for (int i = 0; i < 24; i++) begin
      do_op(2'd3, 1'b1, 16'h0, 16'h0, v16(i), i[0]);
      do_op(2'd2, 1'b1, 16'h0, 16'h0, v16(i+3), ~i[0]);
    end
    // R8: word result with only the upper byte set is not zero
    do_op(2'd2, 1'b1, 16'h0, 16'h0, 16'h0100, 1'b0);
    do_op(2'd2, 1'b0, 16'h0, 16'h0, 16'h0100, 1'b0);

    // R10: whole write, alone and against a simultaneous update
    for (int k = 0; k < 8; k++) begin
      logic [7:0] d;
      d = 8'(k * 37 + 5);
      wr_data = d; wr_en = 1'b1; upd_en = k[0];
      op_class = 2'd0; wide = 1'b0; opnd_a = 16'h00FF; opnd_b = 16'h0001; result = 16'h0000;
      m_ccr = d;
      @(negedge clk);
      chk("R10", ccr_q, d);
      // R9 after a write: an update leaves the new upper bits alone
      do_op(2'd1, 1'b0, 16'h0010, 16'h0020, 16'h00F0, 1'b0);
    end

    // R11: idle cycles with changing inputs hold the register
    wr_en = 1'b0; upd_en = 1'b0;
    for (int k = 0; k < 16; k++) begin
      op_class = 2'(k); wide = k[2]; result = 16'(k * 4111);
      opnd_a = 16'(k * 777); opnd_b = 16'(k * 91); shift_carry = k[0];
      wr_data = 8'(k);
      @(negedge clk);
      chk("R11", ccr_q, m_ccr);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule